// File: doc/BRIEF.md
# Charge Enable Watchdog

This block watches the host that programs a battery charger and decides whether charging may go on. A register decoder upstream pulses `chargeWriteStb` for one clock when a write to the charge-voltage or charge-current setting has completed. Writes to any other setting never produce this pulse, so they cannot restart the watchdog. The block also samples the serial clock line. That level must already be synchronised to `clk`.

Two timeouts run against the host. The first, the inactivity timeout, fires when no qualifying write has arrived for a long time. Its default is 175 s. The second, the stuck-clock timeout, fires when the serial clock line stays low for longer than a short limit. Its default is 25 ms. Both cycle counts are derived from a clock-frequency parameter. Either timeout drops `chargeEn` and sets its own status bit. The output then stays off until another qualifying write arrives.

Top module: `charge_guard`

## Requirements
- R1: After reset `chargeEn`, `inactTimeout` and `sclTimeout` are all 0. Before the first qualifying write they stay 0, whatever `sclLevel` does.
- R2: A clock edge that samples `chargeWriteStb` high sets `chargeEn` to 1 and clears both status bits at that edge.
- R3: Let N = (CLK_HZ/1000)·INACT_MS. If no further qualifying write arrives, `chargeEn` stays 1 for exactly N clock edges after the write edge. It falls at the N-th edge, and at that same edge `inactTimeout` becomes 1.
- R4: Let M = (CLK_HZ/1000000)·SCLLOW_US. While enabled, M consecutive low samples of `sclLevel` are tolerated. The (M+1)-th consecutive low sample clears `chargeEn` and sets `sclTimeout` at that edge.
- R5: Any high sample of `sclLevel` restarts the consecutive-low count from zero.
- R6: Once `chargeEn` is 0, it and both status bits keep their values until a qualifying write arrives. This holds even when `sclLevel` returns high.
- R7: A qualifying write restarts both counts. This applies even when it arrives in the middle of a low period on `sclLevel`. After the write edge, M+1 further low samples are needed to trip the stuck-clock timeout.
- R8: A qualifying write sampled at the same edge at which a timeout would fire takes priority. `chargeEn` stays 1 and no status bit is set.
- R9: A status bit is set only by a timeout that fires while `chargeEn` is 1. For example, the inactivity limit passing after a stuck-clock disable leaves `inactTimeout` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| chargeWriteStb | input | 1 | One-cycle pulse: a charge-voltage or charge-current write has completed |
| sclLevel | input | 1 | Synchronised serial clock line level |
| chargeEn | output | 1 | Charging permitted |
| inactTimeout | output | 1 | Latched: disabled by the inactivity timeout |
| sclTimeout | output | 1 | Latched: disabled by the stuck-low clock timeout |

## Verification
The assertions assume that `chargeWriteStb` is a clean single-clock pulse and that `sclLevel` is already synchronous to `clk`. They also assume both limits are at least two cycles, so that a just-restarted count cannot already be at its limit. The stimulus drives every input on the falling clock edge. It uses scaled limits of 1000 and 20 cycles, so every edge case can be reached.

The stimulus includes three timed events: a write placed exactly on the expiry edge, a write issued in the middle of a low period, and a high glitch one sample before the stuck-clock limit.

// File: rtl/charge_guard_pkg.sv
package charge_guard_pkg;

  // Command strobes from the control to the datapath
  typedef struct packed {
    logic reload;
  } guardCmd_t;

  // Expiry flags from the datapath to the control
  typedef struct packed {
    logic inactExpire;
    logic sclExpire;
  } guardFlags_t;

endpackage

// File: rtl/charge_guard_dp.sv
module charge_guard_dp
  import charge_guard_pkg::*;
#(
  parameter longint unsigned INACT_CYC = 1000,
  parameter longint unsigned SCL_CYC   = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  guardCmd_t   cmd,
  input  logic        sclLevel,
  output guardFlags_t flags
);

  localparam int INACT_W = (INACT_CYC > 2) ? $clog2(INACT_CYC) : 1;
  localparam int SCL_W   = $clog2(SCL_CYC + 1);
  localparam logic [INACT_W-1:0] INACT_LAST = INACT_W'(INACT_CYC - 1);
  localparam logic [SCL_W-1:0]   SCL_LAST   = SCL_W'(SCL_CYC);

  logic [INACT_W-1:0] inactCnt;
  logic [SCL_W-1:0]   sclLowCnt;

  // Edges since the last qualifying write; holds at its limit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inactCnt <= '0;
    end else if (cmd.reload) begin
      inactCnt <= '0;
    end else if (inactCnt != INACT_LAST) begin
      inactCnt <= inactCnt + 1'b1;
    end
  end

  // Consecutive low samples of the clock line; holds at its limit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclLowCnt <= '0;
    end else if (cmd.reload || sclLevel) begin
      sclLowCnt <= '0;
    end else if (sclLowCnt != SCL_LAST) begin
      sclLowCnt <= sclLowCnt + 1'b1;
    end
  end

  always_comb begin
    flags.inactExpire = (inactCnt == INACT_LAST);
    flags.sclExpire   = !sclLevel && (sclLowCnt == SCL_LAST);
  end

  // R5: a high sample leaves no stuck-clock expiry on the next edge
  p_scl_high_restarts_r5: assert property (@(posedge clk) disable iff (!rstN)
    sclLevel |=> !flags.sclExpire);

  // R3: without a reload, an inactivity expiry persists
  p_inact_expiry_holds_r3: assert property (@(posedge clk) disable iff (!rstN)
    (flags.inactExpire && !cmd.reload) |=> flags.inactExpire);

  // R7: a reload clears the inactivity expiry on the following cycle
  p_reload_restarts_r7: assert property (@(posedge clk) disable iff (!rstN)
    cmd.reload |=> !flags.inactExpire);

endmodule

// File: rtl/charge_guard_ctrl.sv
module charge_guard_ctrl
  import charge_guard_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        chargeWriteStb,
  input  guardFlags_t flags,
  output guardCmd_t   cmd,
  output logic        chargeEn,
  output logic        inactTimeout,
  output logic        sclTimeout
);

  always_comb begin
    cmd.reload = chargeWriteStb;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chargeEn     <= 1'b0;
      inactTimeout <= 1'b0;
      sclTimeout   <= 1'b0;
    end else if (chargeWriteStb) begin
      chargeEn     <= 1'b1;
      inactTimeout <= 1'b0;
      sclTimeout   <= 1'b0;
    end else if (chargeEn && (flags.inactExpire || flags.sclExpire)) begin
      chargeEn <= 1'b0;
      if (flags.inactExpire) inactTimeout <= 1'b1;
      if (flags.sclExpire)   sclTimeout   <= 1'b1;
    end
  end

  // R2: a qualifying write enables charging with clean status
  p_write_enables_r2: assert property (@(posedge clk) disable iff (!rstN)
    chargeWriteStb |=> (chargeEn && !inactTimeout && !sclTimeout));

  // R6: the disabled state is sticky until a write
  p_disable_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!chargeEn && !chargeWriteStb) |=> (!chargeEn && $stable(inactTimeout) && $stable(sclTimeout)));

  // R9: a status bit never coexists with an enabled output
  p_status_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    (inactTimeout || sclTimeout) |-> !chargeEn);

  // R3: charging drops only because of an expiry
  p_drop_needs_expiry_r3: assert property (@(posedge clk) disable iff (!rstN)
    (chargeEn && !chargeWriteStb && !flags.inactExpire && !flags.sclExpire) |=> chargeEn);

endmodule

// File: rtl/charge_guard.sv
module charge_guard
  import charge_guard_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 125_000_000,
  parameter int unsigned INACT_MS  = 175_000,
  parameter int unsigned SCLLOW_US = 25_000
) (
  input  logic clk,
  input  logic rstN,
  input  logic chargeWriteStb,
  input  logic sclLevel,
  output logic chargeEn,
  output logic inactTimeout,
  output logic sclTimeout
);

  localparam longint unsigned INACT_CYC =
    longint'(CLK_HZ / 1000) * longint'(INACT_MS);
  localparam longint unsigned SCL_CYC =
    longint'(CLK_HZ / 1_000_000) * longint'(SCLLOW_US);

  guardCmd_t   cmd;
  guardFlags_t flags;

  charge_guard_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .chargeWriteStb (chargeWriteStb),
    .flags          (flags),
    .cmd            (cmd),
    .chargeEn       (chargeEn),
    .inactTimeout   (inactTimeout),
    .sclTimeout     (sclTimeout)
  );

  charge_guard_dp #(
    .INACT_CYC (INACT_CYC),
    .SCL_CYC   (SCL_CYC)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .sclLevel (sclLevel),
    .flags    (flags)
  );

endmodule

// File: tb/charge_guard_tb.sv
module charge_guard_tb;

  localparam int N = 1000;  // inactivity limit in cycles
  localparam int M = 20;    // tolerated low samples

  typedef struct {
    logic  en;
    logic  inact;
    logic  scl;
    string tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chargeWriteStb = 1'b0;
  logic sclLevel = 1'b1;
  logic chargeEn, inactTimeout, sclTimeout;

  int checks = 0;
  int errors = 0;
  expItem_t expQ[$];

  // Model state, built from the requirements
  logic mEn = 1'b0, mInact = 1'b0, mScl = 1'b0;
  logic armed = 1'b0;
  int sinceWrite = 0;
  int lowRun = 0;

  always #4 clk = ~clk;

  charge_guard #(
    .CLK_HZ    (1_000_000),
    .INACT_MS  (1),
    .SCLLOW_US (M)
  ) u_dut (
    .clk            (clk),
    .rstN           (rstN),
    .chargeWriteStb (chargeWriteStb),
    .sclLevel       (sclLevel),
    .chargeEn       (chargeEn),
    .inactTimeout   (inactTimeout),
    .sclTimeout     (sclTimeout)
  );

  // Driver: set inputs for the next edge and predict its result
  task automatic step(input logic w, input logic s, input string tag);
    @(negedge clk);
    chargeWriteStb = w;
    sclLevel = s;
    if (w) begin
      mEn = 1'b1; mInact = 1'b0; mScl = 1'b0;
      armed = 1'b1; sinceWrite = 0; lowRun = 0;
    end else begin
      sinceWrite++;
      lowRun = s ? 0 : lowRun + 1;
      if (armed && mEn) begin
        if (sinceWrite >= N) begin mEn = 1'b0; mInact = 1'b1; end
        if (lowRun >= M + 1) begin mEn = 1'b0; mScl = 1'b1; end
      end
    end
    expQ.push_back('{mEn, mInact, mScl, tag});
  endtask

  task automatic run(input int cycles, input logic s, input string tag);
    for (int i = 0; i < cycles; i++) step(1'b0, s, tag);
  endtask

  // Monitor: compare two ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      checks++;
      if ({chargeEn, inactTimeout, sclTimeout} !== {e.en, e.inact, e.scl}) begin
        errors++;
        $display("FAIL %s: en/inact/scl got %b%b%b expected %b%b%b at %0t",
                 e.tag, chargeEn, inactTimeout, sclTimeout, e.en, e.inact, e.scl, $time);
      end
    end
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if ({chargeEn, inactTimeout, sclTimeout} !== 3'b000) begin
      errors++;
      $display("FAIL R1: reset outputs got %b%b%b expected 000", chargeEn, inactTimeout, sclTimeout);
    end
    rstN = 1'b1;
    // R1: nothing happens before the first write
    run(40, 1'b0, "R1");
    run(10, 1'b1, "R1");
    // R2, R3: write then idle past the inactivity limit
    step(1'b1, 1'b1, "R2");
    run(N + 5, 1'b1, "R3");
    // R6: stays off
    run(20, 1'b1, "R6");
    // R4: stuck-low clock trips at M+1 low samples
    step(1'b1, 1'b1, "R2");
    run(100, 1'b1, "R4");
    run(M + 5, 1'b0, "R4");
    // R6: clock returning high does not clear
    run(30, 1'b1, "R6");
    // R9: inactivity limit passes while disabled
    run(N + 50, 1'b1, "R9");
    // R5: high glitch restarts the low count
    step(1'b1, 1'b1, "R2");
    run(M, 1'b0, "R5");
    run(1, 1'b1, "R5");
    run(M, 1'b0, "R5");
    run(5, 1'b1, "R5");
    // R7: write in the middle of a low period
    run(10, 1'b0, "R7");
    step(1'b1, 1'b0, "R7");
    run(M + 5, 1'b0, "R7");
    // R8: write on the exact expiry edge
    step(1'b1, 1'b1, "R8");
    run(N - 1, 1'b1, "R8");
    step(1'b1, 1'b1, "R8");
    run(N + 3, 1'b1, "R8");
    run(2, 1'b1, "R6");
    @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule